// File: doc/BRIEF.md
# Wavefront Global Memory Coalescer

This block sits between the load unit of one wavefront and a wide global memory port. The load unit hands over one request for the whole wavefront. The request holds a lane enable mask and one byte address per lane. The coalescer groups the enabled lanes by the 128-byte segment their addresses fall in. It then issues one wide read for each distinct segment, lowest segment first. Each returned segment is scattered to every waiting lane whose address lies inside it. Lanes that share a word receive copies of a single fetched value. Aligned, consecutive lane addresses therefore cost one memory transaction, however many lanes take part.

Both stream edges use valid/ready. The load side is a single request channel: `req_ready` is high only while the block is idle, and a request is taken on the edge where `req_valid` and `req_ready` are both high. On the memory side, a request holds `mem_req_valid` and `mem_req_addr` unchanged until `mem_req_ready` accepts it. Only one segment read is outstanding at a time. `mem_rsp_ready` is high exactly while that read awaits its data, so the memory may stall the response for any number of cycles. When the last segment arrives, a one-cycle `done` pulse marks `lane_data` valid. `lane_data` then holds its value until the next request is accepted. `txn_count` reports how many segment reads the request cost.

Top module: `wf_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mem_req_valid`, `mem_rsp_ready` and `txn_count` are 0. `req_ready` is 1 exactly when no request is in progress.
- R2: A request with a nonzero mask issues exactly one memory read for each distinct segment (address bits [31:7]) touched by an enabled lane. `mem_req_addr` is the segment base, with bits [6:0] zero.
- R3: Within one request, the segment reads are issued in strictly ascending address order.
- R4: Once `mem_req_valid` is raised, it and `mem_req_addr` stay stable until `mem_req_ready` accepts the read. No further read is issued until the response has been taken. `mem_rsp_ready` is 1 only while a read is outstanding.
- R5: An enabled lane receives word number addr[6:2] of the response for its segment. Word k sits at `mem_rsp_data[32k+31:32k]`, and lane i's result at `lane_data[32i+31:32i]`.
- R6: Enabled lanes that share a word (or a segment) get their data from one response and add no extra read.
- R7: Address bits [1:0] are ignored.
- R8: `done` rises for exactly one cycle, in the cycle after the handshake of the last response. In that cycle, `req_ready` is 1 and disabled lanes read 0 in `lane_data`.
- R9: `txn_count` changes only together with `done`, and then equals the number of reads that request issued.
- R10: An all-zero mask issues no memory read and gives `done` in the cycle after acceptance, with `txn_count` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Wavefront load request valid |
| req_ready | output | 1 | Block idle, request accepted when both high |
| req_mask | input | LANES | Lane enable mask |
| req_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane i at [32i+31:32i] |
| mem_req_valid | output | 1 | Segment read request valid |
| mem_req_ready | input | 1 | Memory accepts the segment read |
| mem_req_addr | output | ADDR_W | Segment base byte address |
| mem_rsp_valid | input | 1 | Segment data valid |
| mem_rsp_ready | output | 1 | Block waiting for segment data |
| mem_rsp_data | input | SEG_WORDS*DATA_W | Full segment, word k at [32k+31:32k] |
| done | output | 1 | One-cycle completion pulse |
| lane_data | output | LANES*DATA_W | Per-lane load results |
| txn_count | output | CNT_W | Segment reads issued for the last request |

## Verification
A wrong pending-lane mask or segment selection shows at `mem_req_addr`. It appears as a missing, repeated or out-of-order segment, and shows on the very cycle the faulty read is presented. A bad word offset or a lane written from the wrong response shows only at the `done` pulse, as a wrong `lane_data` word. A control slip, such as a read issued while one is outstanding or completion one cycle early or late, is visible within one cycle on `mem_req_valid`, `mem_rsp_ready`, `req_ready` or `done`. A miscounted transaction is caught at the next `done` through `txn_count`.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } wfc_state_t;
endpackage

// File: rtl/wfc_seg_picker.sv
// Finds the lowest segment among pending lanes and the lanes that share it.
module wfc_seg_picker #(
  parameter int LANES = 32,
  parameter int SEG_W = 25
) (
  input  logic [LANES-1:0]       pend,
  input  logic [LANES*SEG_W-1:0] seg_flat,
  output logic [SEG_W-1:0]       min_seg,
  output logic [LANES-1:0]       hit,
  output logic                   any
);
  always_comb begin
    min_seg = '1;
    any     = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (!any || seg_flat[i*SEG_W +: SEG_W] < min_seg)) begin
        min_seg = seg_flat[i*SEG_W +: SEG_W];
        any     = 1'b1;
      end
    end
    for (int i = 0; i < LANES; i++) begin
      hit[i] = pend[i] && (seg_flat[i*SEG_W +: SEG_W] == min_seg);
    end
  end
endmodule

// File: rtl/wfc_lane_scatter.sv
// Per-lane result registers, loaded from the word a lane selects in a segment.
module wfc_lane_scatter #(
  parameter int LANES     = 32,
  parameter int DATA_W    = 32,
  parameter int SEG_WORDS = 32,
  localparam int WOFF_W   = $clog2(SEG_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          wr_en,
  input  logic [LANES-1:0]              hit,
  input  logic [LANES*WOFF_W-1:0]       off_flat,
  input  logic [SEG_WORDS*DATA_W-1:0]   seg_data,
  output logic [LANES*DATA_W-1:0]       lane_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WOFF_W-1:0] off;
    logic [DATA_W-1:0] word;
    assign off  = off_flat[g*WOFF_W +: WOFF_W];
    assign word = seg_data[off*DATA_W +: DATA_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lane_data[g*DATA_W +: DATA_W] <= '0;
      else if (clear)            lane_data[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en && hit[g])  lane_data[g*DATA_W +: DATA_W] <= word;
    end
  end
endmodule

// File: rtl/wf_coalescer.sv
module wf_coalescer #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SEG_WORDS = 32,
  localparam int BYTE_W   = $clog2(DATA_W/8),
  localparam int WOFF_W   = $clog2(SEG_WORDS),
  localparam int OFF_W    = WOFF_W + BYTE_W,
  localparam int SEG_W    = ADDR_W - OFF_W,
  localparam int CNT_W    = $clog2(LANES+1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [LANES-1:0]            req_mask,
  input  logic [LANES*ADDR_W-1:0]     req_addr,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-1:0]           mem_req_addr,
  input  logic                        mem_rsp_valid,
  output logic                        mem_rsp_ready,
  input  logic [SEG_WORDS*DATA_W-1:0] mem_rsp_data,
  output logic                        done,
  output logic [LANES*DATA_W-1:0]     lane_data,
  output logic [CNT_W-1:0]            txn_count
);
  import wfc_pkg::*;

  wfc_state_t                state;
  logic [LANES-1:0]          pend;
  logic [LANES*SEG_W-1:0]    seg_q;
  logic [LANES*WOFF_W-1:0]   off_q;
  logic [CNT_W-1:0]          cnt;
  logic [SEG_W-1:0]          min_seg;
  logic [LANES-1:0]          hit;
  logic                      any_pend;
  logic                      accept, issue_hs, rsp_hs;
  logic [LANES-1:0]          pend_left;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_rsp_ready = (state == ST_WAIT);
  assign mem_req_addr  = {min_seg, {OFF_W{1'b0}}};
  assign accept        = req_valid && req_ready;
  assign issue_hs      = mem_req_valid && mem_req_ready;
  assign rsp_hs        = mem_rsp_valid && mem_rsp_ready;
  assign pend_left     = pend & ~hit;

  // Address split: segment id and word offset kept, byte bits dropped.
  for (genvar g = 0; g < LANES; g++) begin : g_split
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g*SEG_W +: SEG_W]   <= '0;
        off_q[g*WOFF_W +: WOFF_W] <= '0;
      end else if (accept) begin
        seg_q[g*SEG_W +: SEG_W]   <= req_addr[g*ADDR_W+OFF_W +: SEG_W];
        off_q[g*WOFF_W +: WOFF_W] <= req_addr[g*ADDR_W+BYTE_W +: WOFF_W];
      end
    end
  end

  wfc_seg_picker #(.LANES(LANES), .SEG_W(SEG_W)) u_pick (
    .pend     (pend),
    .seg_flat (seg_q),
    .min_seg  (min_seg),
    .hit      (hit),
    .any      (any_pend)
  );

  wfc_lane_scatter #(.LANES(LANES), .DATA_W(DATA_W), .SEG_WORDS(SEG_WORDS)) u_scat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .wr_en     (rsp_hs),
    .hit       (hit),
    .off_flat  (off_q),
    .seg_data  (mem_rsp_data),
    .lane_data (lane_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend      <= '0;
      cnt       <= '0;
      txn_count <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          pend <= req_mask;
          cnt  <= '0;
          if (req_mask == '0) begin
            done      <= 1'b1;
            txn_count <= '0;
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) begin
          state <= ST_WAIT;
          cnt   <= cnt + 1'b1;
        end
        ST_WAIT: if (mem_rsp_valid) begin
          pend <= pend_left;
          if (pend_left == '0) begin
            state     <= ST_IDLE;
            done      <= 1'b1;
            txn_count <= cnt;
          end else begin
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-side record of the last segment read issued in this request.
  logic [ADDR_W-1:0] last_addr;
  logic              have_last;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      have_last <= 1'b0;
    end else if (accept) begin
      have_last <= 1'b0;
    end else if (issue_hs) begin
      last_addr <= mem_req_addr;
      have_last <= 1'b1;
    end
  end

  // R3
  seg_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && have_last |-> mem_req_addr > last_addr);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R4
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hs |=> !mem_req_valid && mem_rsp_ready);

  // R2
  pending_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid || mem_rsp_ready |-> any_pend);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hs && (pend_left == '0) |=> done && req_ready);

  // R9
  count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(txn_count));
endmodule

// File: tb/wf_coalescer_tb.sv
module wf_coalescer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 32;
  localparam int CW = $clog2(LANES+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_ready;
  logic [SW*DW-1:0] mem_rsp_data = '0;
  logic done;
  logic [LANES*DW-1:0] lane_data;
  logic [CW-1:0] txn_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  wf_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .done(done), .lane_data(lane_data),
    .txn_count(txn_count)
  );

  int vectors = 0;
  int miscompares = 0;

  // Reference model state
  bit busy = 0, outstanding = 0, done_next = 0, acc_seen = 0;
  logic [31:0] segs[$];
  logic [31:0] rsp_seg = '0;
  int dly = 0;
  int exp_cnt = 0, last_cnt = 0, done_cnt = 0;
  logic [LANES*DW-1:0] exp_lane = '0;
  logic nxt_mrr = 0, nxt_rv = 0;
  logic [SW*DW-1:0] nxt_rd = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_accept();
    logic [31:0] s;
    bit found;
    int pos;
    segs.delete();
    exp_lane = '0;
    for (int i = 0; i < LANES; i++) begin
      if (req_mask[i]) begin
        s = {req_addr[i*AW+7 +: 25], 7'b0};
        exp_lane[i*DW +: DW] = mem_word({req_addr[i*AW+2 +: 30], 2'b00});
        found = 0;
        pos = segs.size();
        for (int k = 0; k < segs.size(); k++) begin
          if (segs[k] == s) found = 1;
          if (!found && pos == segs.size() && segs[k] > s) pos = k;
        end
        if (!found) segs.insert(pos, s);
      end
    end
    exp_cnt = segs.size();
  endtask

  always begin
    bit acc, mh, rh;
    @(negedge clk);
    if (rst_n) begin
      chk(req_ready == !busy, "R1", "req_ready", 64'(req_ready), 64'(!busy));
      chk(mem_req_valid == (busy && !outstanding && segs.size() > 0), "R4",
          "mem_req_valid", 64'(mem_req_valid), 64'(busy && !outstanding && segs.size() > 0));
      chk(mem_rsp_ready == outstanding, "R4", "mem_rsp_ready",
          64'(mem_rsp_ready), 64'(outstanding));
      chk(done == done_next, "R8", "done", 64'(done), 64'(done_next));
      if (done_next) last_cnt = exp_cnt;
      chk(txn_count == CW'(last_cnt), "R9", "txn_count", 64'(txn_count), 64'(last_cnt));
      if (mem_req_valid && segs.size() > 0)
        chk(mem_req_addr == segs[0], "R3", "segment address/order",
            64'(mem_req_addr), 64'(segs[0]));
      if (done && done_next) begin
        for (int i = 0; i < LANES; i++)
          chk(lane_data[i*DW +: DW] == exp_lane[i*DW +: DW], "R5/R6",
              $sformatf("lane %0d data", i), 64'(lane_data[i*DW +: DW]),
              64'(exp_lane[i*DW +: DW]));
      end
      if (done) done_cnt++;
      acc = req_valid && req_ready;
      mh  = mem_req_valid && mem_req_ready;
      rh  = mem_rsp_valid && mem_rsp_ready;
      done_next = 0;
      if (acc) begin
        acc_seen = 1;
        model_accept();
        if (req_mask == '0) done_next = 1;
        else busy = 1;
      end
      if (mh) begin
        rsp_seg = mem_req_addr;
        if (segs.size() > 0) void'(segs.pop_front());
        outstanding = 1;
        dly = $urandom_range(0, 2);
      end else if (outstanding && !mem_rsp_valid && dly > 0) begin
        dly--;
      end
      if (rh) begin
        outstanding = 0;
        if (segs.size() == 0 && busy) begin
          busy = 0;
          done_next = 1;
        end
      end
      nxt_mrr = ($urandom_range(0, 9) < 7);
      nxt_rv  = outstanding && dly == 0;
      for (int w = 0; w < SW; w++) nxt_rd[w*DW +: DW] = mem_word(rsp_seg + 32'(w*4));
    end else begin
      busy = 0; outstanding = 0; done_next = 0; segs.delete(); last_cnt = 0;
      nxt_mrr = 0; nxt_rv = 0;
    end
    @(posedge clk);
    #1;
    mem_req_ready = nxt_mrr;
    mem_rsp_valid = nxt_rv;
    mem_rsp_data  = nxt_rv ? nxt_rd : '0;
  end

  task automatic send(input logic [LANES-1:0] m, input logic [AW-1:0] a[LANES]);
    int start;
    start = done_cnt;
    @(posedge clk); #2;
    acc_seen = 0;
    req_valid = 1'b1;
    req_mask = m;
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = a[i];
    do begin @(posedge clk); #2; end while (!acc_seen);
    req_valid = 1'b0;
    while (done_cnt == start) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [AW-1:0] a[LANES];
    logic [24:0] bases[4];
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
    chk(done === 1'b0 && mem_req_valid === 1'b0 && mem_rsp_ready === 1'b0, "R1",
        "reset control", 64'({done, mem_req_valid, mem_rsp_ready}), 64'd0);
    chk(txn_count === '0, "R1", "reset txn_count", 64'(txn_count), 64'd0);
    // R2 aligned contiguous: one segment
    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 32'(i*4);
    send('1, a);
    chk(txn_count == 1, "R2", "contiguous count", 64'(txn_count), 64'd1);
    // R6 broadcast of one word
    for (int i = 0; i < LANES; i++) a[i] = 32'h2344;
    send('1, a);
    chk(txn_count == 1, "R6", "broadcast count", 64'(txn_count), 64'd1);
    // R2 stride of two words: two segments
    for (int i = 0; i < LANES; i++) a[i] = 32'h4000 + 32'(i*8);
    send('1, a);
    chk(txn_count == 2, "R2", "stride count", 64'(txn_count), 64'd2);
    // R3 descending lanes, reads must come out ascending
    for (int i = 0; i < LANES; i++) a[i] = 32'h8000 + 32'((31-i)*128) + 32'(i*4);
    send('1, a);
    chk(txn_count == 32, "R3", "scattered count", 64'(txn_count), 64'd32);
    // R7 low address bits ignored
    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 32'(i*4) + 32'(i%4);
    send('1, a);
    chk(txn_count == 1, "R7", "misaligned count", 64'(txn_count), 64'd1);
    // R8 partial mask, disabled lanes read zero
    for (int i = 0; i < LANES; i++) a[i] = 32'h5000 + 32'(i*4);
    send(32'h0000F00F, a);
    // R10 empty mask
    send('0, a);
    chk(txn_count == 0, "R10", "empty count", 64'(txn_count), 64'd0);
    // R2 contiguous run crossing a segment boundary
    for (int i = 0; i < LANES; i++) a[i] = 32'h3040 + 32'(i*4);
    send('1, a);
    chk(txn_count == 2, "R2", "crossing count", 64'(txn_count), 64'd2);
    // Random patterns over a few segments
    for (int t = 0; t < 150; t++) begin
      for (int k = 0; k < 4; k++) bases[k] = 25'($urandom);
      for (int i = 0; i < LANES; i++)
        a[i] = {bases[$urandom_range(0, 3)], 5'($urandom), 2'($urandom)};
      send(32'($urandom) | ((t % 3 == 0) ? 32'hFFFFFFFF : 32'h0), a);
    end
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule